// File: doc/BRIEF.md
# DRAM Control-Strobe Cycle Classifier

This block sits beside an asynchronous page-mode DRAM bus and watches only the row strobe, column strobe and write-enable lines. It does not drive them. It samples them with a fast system clock and measures the time between their edges in clock cycles. For every row-strobe low period it reports what kind of memory cycle took place: read, early write, read-modify-write, row-only refresh, column-before-row refresh, hidden refresh, self refresh, test-mode entry, or a write whose timing fits no defined write class.

Every time threshold is a nanosecond parameter. The block divides it by the clock period and rounds up. The cycle type is decided from the order of the edges and from how far apart they are, not from the pin levels at a single instant. One result is issued per row-strobe low period, as a single-cycle pulse. The block also watches the row-strobe high time that follows a self refresh, and raises an error pulse if that precharge is too short.

Top module: `dram_cycle_mon`

## Requirements
- R1: While reset is asserted and right after it, `ev_valid` and `err_rps` stay 0.
- R2: A row-strobe low period in which the column strobe falls while write-enable stays high is reported with code 1 (read).
- R3: If write-enable is already low when the column strobe falls, the period is reported with code 2 (early write).
- R4: If write-enable falls while the column strobe is low, at least ceil(40 ns / clock period) cycles after the column-strobe fall and at least ceil(85 ns / clock period) cycles after the row-strobe fall, the period is reported with code 3 (read-modify-write). At 5 ns these limits are 8 and 17 cycles.
- R5: If write-enable falls while the column strobe is low and either limit of R4 is not met, the period is reported with code 9 (indeterminate write). Code 9 takes priority over code 3, and code 3 over code 2.
- R6: A row-strobe low period that begins with the column strobe high and contains no column-strobe fall is reported with code 4 (row-only refresh).
- R7: A row-strobe fall with the column strobe already low is a refresh cycle. Unless R8, R9 or R10 applies, it is reported with code 5 (column-before-row refresh).
- R8: In such a refresh cycle, write-enable low for at least ceil(10 ns / period) cycles before the row-strobe fall, and still low for at least that many cycles after it, is reported with code 8 (test-mode entry).
- R9: If the column strobe stays low from a cycle reported as a read (code 1) while the row strobe rises and falls again, the new period is reported with code 6 (hidden refresh). Repeated row pulses keep this class until the column strobe rises. A column strobe held from a write cycle gives code 5 instead.
- R10: A column-before-row refresh cycle whose row-strobe low time is at least ceil(100000 ns / period) cycles (20000 at 5 ns) is reported with code 7 (self refresh).
- R11: After a code 7, the next row-strobe high time is measured. If it is shorter than ceil(110 ns / period) cycles (22 at 5 ns), `err_rps` pulses for one cycle shortly after that row-strobe fall. Otherwise no error is raised.
- R12: Exactly one `ev_valid` pulse, one cycle wide, is produced per row-strobe low period, after the row-strobe rise that ends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe from the bus, active low |
| cas_n | input | 1 | Column strobe from the bus, active low |
| we_n | input | 1 | Write enable from the bus, active low |
| ev_valid | output | 1 | One-cycle pulse: a cycle has been classified |
| ev_code | output | 4 | Cycle class code, valid with `ev_valid` |
| err_rps | output | 1 | One-cycle pulse: precharge after self refresh was too short |

## Verification
The hardest situation to reach from the ports is the self-refresh precharge check. It needs a row-strobe low period of more than 20000 cycles, followed by a high time close to the limit. The stimulus holds the row strobe low with the column strobe already low for just over the self-refresh length. It then releases the row strobe for 10, 21 and 22 cycles, so that both sides of the boundary are covered. The read-modify-write limits are also tested one cycle either side of the column-to-write distance. Hidden refresh is tested against a column strobe held over from a write.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [3:0] {
    EV_NONE     = 4'd0,
    EV_READ     = 4'd1,
    EV_EWRITE   = 4'd2,
    EV_RMW      = 4'd3,
    EV_ROW_ONLY = 4'd4,
    EV_CBR      = 4'd5,
    EV_HIDDEN   = 4'd6,
    EV_SELF     = 4'd7,
    EV_TEST     = 4'd8,
    EV_INDET    = 4'd9
  } ev_code_e;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_ACCESS = 2'd1,
    M_CBR    = 2'd2,
    M_HIDDEN = 2'd3
  } mode_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], din[i]};
    end
    assign lvl[i] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
  assign rise = ~prev_q & lvl;

endmodule

// File: rtl/dcm_span.sv
module dcm_span #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = start || (cnt_q != MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (start) cnt_d = CW'(1);
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/dcm_classify.sv
module dcm_classify
  import dcm_pkg::*;
#(
  parameter int CW     = 16,
  parameter int T_CWD  = 8,
  parameter int T_RWD  = 17,
  parameter int T_SELF = 20000,
  parameter int T_RPS  = 22,
  parameter int T_WTS  = 2,
  parameter int T_WTH  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_fall,
  input  logic          ras_rise,
  input  logic          cas_lvl,
  input  logic          cas_fall,
  input  logic          cas_rise,
  input  logic          we_lvl,
  input  logic          we_fall,
  input  logic          we_rise,
  input  logic [CW-1:0] span_rlow,
  input  logic [CW-1:0] span_rhigh,
  input  logic [CW-1:0] span_cas,
  input  logic [CW-1:0] span_we,
  output logic          ev_valid,
  output logic [3:0]    ev_code,
  output logic          err_rps
);

  localparam logic [CW-1:0] T_CWD_C  = CW'(T_CWD);
  localparam logic [CW-1:0] T_RWD_C  = CW'(T_RWD);
  localparam logic [CW-1:0] T_SELF_C = CW'(T_SELF);
  localparam logic [CW-1:0] T_RPS_C  = CW'(T_RPS);
  localparam logic [CW-1:0] T_WTS_C  = CW'(T_WTS);
  localparam logic [CW-1:0] T_WTH_C  = CW'(T_WTH);

  mode_e      mode_q, mode_d;
  logic       seen_q, seen_d;
  logic       early_q, early_d;
  logic       rmw_q, rmw_d;
  logic       indet_q, indet_d;
  logic       test_q, test_d;
  logic       hid_q, hid_d;
  logic       sr_q, sr_d;
  logic       vld_q, vld_d;
  logic [3:0] code_q, code_d;
  logic       err_q, err_d;
  ev_code_e   acc_code;
  logic       long_low;

  assign long_low = (span_rlow >= T_SELF_C);

  // class of a normal access cycle from the flags it collected
  always_comb begin
    if (!seen_q)      acc_code = EV_ROW_ONLY;
    else if (indet_q) acc_code = EV_INDET;
    else if (rmw_q)   acc_code = EV_RMW;
    else if (early_q) acc_code = EV_EWRITE;
    else              acc_code = EV_READ;
  end

  always_comb begin
    mode_d  = mode_q;
    seen_d  = seen_q;
    early_d = early_q;
    rmw_d   = rmw_q;
    indet_d = indet_q;
    test_d  = test_q;
    hid_d   = hid_q;
    sr_d    = sr_q;
    vld_d   = 1'b0;
    code_d  = code_q;
    err_d   = 1'b0;
    if (cas_rise) hid_d = 1'b0;
    unique case (mode_q)
      M_IDLE: begin
        if (ras_fall) begin
          seen_d  = 1'b0;
          early_d = 1'b0;
          rmw_d   = 1'b0;
          indet_d = 1'b0;
          test_d  = 1'b0;
          if (sr_q) begin
            err_d = (span_rhigh < T_RPS_C);
            sr_d  = 1'b0;
          end
          if (!cas_lvl) begin
            mode_d = hid_q ? M_HIDDEN : M_CBR;
            test_d = !hid_q && !we_lvl && (span_we >= T_WTS_C);
          end else begin
            mode_d = M_ACCESS;
          end
        end
      end
      M_ACCESS: begin
        if (ras_rise) begin
          vld_d  = 1'b1;
          code_d = acc_code;
          mode_d = M_IDLE;
          hid_d  = (acc_code == EV_READ) && !cas_lvl;
        end else if (cas_fall) begin
          seen_d = 1'b1;
          if (!we_lvl) early_d = 1'b1;
        end else if (we_fall && !cas_lvl) begin
          if ((span_cas >= T_CWD_C) && (span_rlow >= T_RWD_C)) rmw_d = 1'b1;
          else                                                  indet_d = 1'b1;
        end
      end
      M_CBR: begin
        if (ras_rise) begin
          vld_d  = 1'b1;
          mode_d = M_IDLE;
          hid_d  = 1'b0;
          if (test_q)        code_d = EV_TEST;
          else if (long_low) code_d = EV_SELF;
          else               code_d = EV_CBR;
          sr_d = !test_q && long_low;
        end else if (we_rise && (span_rlow < T_WTH_C)) begin
          test_d = 1'b0;
        end
      end
      M_HIDDEN: begin
        if (ras_rise) begin
          vld_d  = 1'b1;
          code_d = EV_HIDDEN;
          mode_d = M_IDLE;
          hid_d  = !cas_lvl;
        end
      end
      default: mode_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      seen_q  <= 1'b0;
      early_q <= 1'b0;
      rmw_q   <= 1'b0;
      indet_q <= 1'b0;
      test_q  <= 1'b0;
      hid_q   <= 1'b0;
      sr_q    <= 1'b0;
      vld_q   <= 1'b0;
      code_q  <= EV_NONE;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      seen_q  <= seen_d;
      early_q <= early_d;
      rmw_q   <= rmw_d;
      indet_q <= indet_d;
      test_q  <= test_d;
      hid_q   <= hid_d;
      sr_q    <= sr_d;
      vld_q   <= vld_d;
      code_q  <= code_d;
      err_q   <= err_d;
    end
  end

  assign ev_valid = vld_q;
  assign ev_code  = code_q;
  assign err_rps  = err_q;

  // R10: a self refresh report needs the measured low time behind it
  p_self_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && code_q == EV_SELF) |-> ($past(span_rlow) >= T_SELF_C));

  // R11: the error pulse follows a row-strobe fall
  p_err_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(ras_fall));

endmodule

// File: rtl/dram_cycle_mon.sv
module dram_cycle_mon
  import dcm_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int CWD_NS      = 40,
  parameter int RWD_NS      = 85,
  parameter int SELF_NS     = 100000,
  parameter int RPS_NS      = 110,
  parameter int WTS_NS      = 10,
  parameter int WTH_NS      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output logic       ev_valid,
  output logic [3:0] ev_code,
  output logic       err_rps
);

  localparam int T_CWD  = ns_to_cyc(CWD_NS, CLK_NS);
  localparam int T_RWD  = ns_to_cyc(RWD_NS, CLK_NS);
  localparam int T_SELF = ns_to_cyc(SELF_NS, CLK_NS);
  localparam int T_RPS  = ns_to_cyc(RPS_NS, CLK_NS);
  localparam int T_WTS  = ns_to_cyc(WTS_NS, CLK_NS);
  localparam int T_WTH  = ns_to_cyc(WTH_NS, CLK_NS);
  localparam int CW     = $clog2(T_SELF + 2);
  localparam int NSPAN  = 4;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sh_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i_n = rst_sh_q[1];

  // bit 0 row strobe, bit 1 column strobe, bit 2 write enable
  logic [2:0] lvl, fall, rise;
  dcm_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .din  ({we_n, cas_n, ras_n}),
    .lvl  (lvl),
    .fall (fall),
    .rise (rise)
  );

  // span 0 row low, 1 row high, 2 column low, 3 write low
  logic [NSPAN-1:0] span_start;
  logic [CW-1:0]    span [NSPAN];
  assign span_start = {fall[2], fall[1], rise[0], fall[0]};

  for (genvar k = 0; k < NSPAN; k++) begin : g_span
    dcm_span #(.CW(CW)) u_span (
      .clk  (clk),
      .rst_n(rst_i_n),
      .start(span_start[k]),
      .cnt  (span[k])
    );
  end

  dcm_classify #(
    .CW(CW), .T_CWD(T_CWD), .T_RWD(T_RWD), .T_SELF(T_SELF),
    .T_RPS(T_RPS), .T_WTS(T_WTS), .T_WTH(T_WTH)
  ) u_cls (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ras_fall  (fall[0]),
    .ras_rise  (rise[0]),
    .cas_lvl   (lvl[1]),
    .cas_fall  (fall[1]),
    .cas_rise  (rise[1]),
    .we_lvl    (lvl[2]),
    .we_fall   (fall[2]),
    .we_rise   (rise[2]),
    .span_rlow (span[0]),
    .span_rhigh(span[1]),
    .span_cas  (span[2]),
    .span_we   (span[3]),
    .ev_valid  (ev_valid),
    .ev_code   (ev_code),
    .err_rps   (err_rps)
  );

  // R12: reports are single-cycle and only follow a row-strobe rise
  p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    ev_valid |=> !ev_valid);
  p_after_rise_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    ev_valid |-> $past(rise[0]));
  // R9: hidden refresh only while the column strobe is held low
  p_hidden_cas_low_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ev_valid && ev_code == EV_HIDDEN) |-> $past(!lvl[1]));
  // R11: the precharge error is raised while the row strobe is low again
  p_err_ras_low_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_rps |-> !lvl[0]);

endmodule

// File: tb/tb_dram_cycle_mon.sv
`timescale 1ns/1ps
module tb_dram_cycle_mon;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras_n, cas_n, we_n;
  logic       ev_valid, err_rps;
  logic [3:0] ev_code;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  bit prev_vld = 1'b0;

  logic [4:0] exp_q [$];
  string      req_q [$];

  localparam logic [4:0] ERR_MARK = 5'h10;

  always #2.5 clk = ~clk;

  dram_cycle_mon dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ev_valid(ev_valid), .ev_code(ev_code), .err_rps(err_rps)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [4:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ev_valid && prev_vld) chk(1'b0, "R12", "valid wider than one cycle", 2, 1);
      prev_vld = ev_valid;
      if (err_rps) begin
        if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected error pulse", 1, 0);
        else begin
          logic [4:0] e; string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          chk(e == ERR_MARK, r, "error pulse in place of event", int'(ERR_MARK), int'(e));
        end
      end
      if (ev_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R12", "unexpected event code", int'(ev_code), 0);
        else begin
          logic [4:0] e; string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          chk({1'b0, ev_code} == e, r, "event code", int'(ev_code), int'(e));
        end
      end
    end
  end

  // normal access: optional early write-enable or write-enable fall after CAS
  task automatic access(input int cas_dly, input bit we_pre, input int we_after,
                        input logic [3:0] code, input string req);
    push({1'b0, code}, req);
    ras_n = 1'b0;
    w(cas_dly - 1);
    if (we_pre) we_n = 1'b0;
    w(1);
    cas_n = 1'b0;
    if (we_after > 0) begin w(we_after); we_n = 1'b0; end
    w(4); cas_n = 1'b1;
    w(3); ras_n = 1'b1; we_n = 1'b1;
    w(12);
  endtask

  task automatic test_cyc(input int setup, input int hold, input logic [3:0] code,
                          input string req);
    push({1'b0, code}, req);
    cas_n = 1'b0; w(2);
    we_n = 1'b0; w(setup);
    ras_n = 1'b0; w(hold);
    we_n = 1'b1; w(15);
    ras_n = 1'b1; w(3);
    cas_n = 1'b1; w(12);
  endtask

  task automatic self_cyc(input int pre, input bit err_exp);
    push({1'b0, 4'd7}, "R10");
    if (err_exp) push(ERR_MARK, "R11");
    push({1'b0, 4'd5}, "R11");
    cas_n = 1'b0; w(3);
    ras_n = 1'b0; w(20005);
    ras_n = 1'b1; w(pre);
    ras_n = 1'b0; w(20);
    ras_n = 1'b1; w(3);
    cas_n = 1'b1; w(30);
  endtask

  initial begin
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      w(1);
      chk(ev_valid == 1'b0, "R1", "valid in reset", int'(ev_valid), 0);
      chk(err_rps == 1'b0, "R1", "error in reset", int'(err_rps), 0);
    end
    rst_n = 1'b1;
    w(8);
    chk(ev_valid == 1'b0 && err_rps == 1'b0, "R1", "outputs after reset",
        int'(ev_valid) + int'(err_rps), 0);

    access(4, 1'b0, 0, 4'd1, "R2");
    access(4, 1'b1, 0, 4'd2, "R3");
    access(5, 1'b0, 15, 4'd3, "R4");
    access(9, 1'b0, 8, 4'd3, "R4");   // exactly 8 after CAS, 17 after RAS
    access(10, 1'b0, 7, 4'd9, "R5");  // one cycle short of the CAS limit
    access(2, 1'b0, 10, 4'd9, "R5");  // RAS limit missed
    // R6: row-only refresh
    push({1'b0, 4'd4}, "R6");
    ras_n = 1'b0; w(20); ras_n = 1'b1; w(12);
    // R7: column-before-row refresh
    push({1'b0, 4'd5}, "R7");
    cas_n = 1'b0; w(3); ras_n = 1'b0; w(20); ras_n = 1'b1; w(3); cas_n = 1'b1; w(12);
    // R8: test entry and its setup/hold boundaries
    test_cyc(3, 3, 4'd8, "R8");
    test_cyc(2, 2, 4'd8, "R8");
    test_cyc(1, 3, 4'd5, "R8");
    test_cyc(3, 1, 4'd5, "R8");
    // R9: read with CAS held, two hidden refresh pulses
    push({1'b0, 4'd1}, "R9");
    push({1'b0, 4'd6}, "R9");
    push({1'b0, 4'd6}, "R9");
    ras_n = 1'b0; w(4); cas_n = 1'b0; w(10); ras_n = 1'b1; w(10);
    ras_n = 1'b0; w(15); ras_n = 1'b1; w(10);
    ras_n = 1'b0; w(15); ras_n = 1'b1; w(5); cas_n = 1'b1; w(12);
    // R9: CAS held from a write is a plain refresh
    push({1'b0, 4'd2}, "R9");
    push({1'b0, 4'd5}, "R9");
    ras_n = 1'b0; w(3); we_n = 1'b0; w(1); cas_n = 1'b0; w(5);
    ras_n = 1'b1; we_n = 1'b1; w(10);
    ras_n = 1'b0; w(15); ras_n = 1'b1; w(3); cas_n = 1'b1; w(12);
    // R10/R11: self refresh and precharge boundary
    self_cyc(10, 1'b1);
    self_cyc(22, 1'b0);
    self_cyc(21, 1'b1);

    w(30);
    chk(exp_q.size() == 0, "R12", "events still outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule